// File: doc/BRIEF.md
# Hash Engine Register Front-End

This block is the register-facing half of a message-digest accelerator. Software reaches it through a 32-bit read/write register port. It uses that port to set the message length, to pick the algorithm and the byte order, and to manage interrupts. Message data enters on a separate one-word write port. When the configuration allows it, the block forwards that data to the digest engine.

Writing the control register starts the engine and empties the result store. The engine then returns its digest words one per beat, and the block captures them. Software reads them back through one queue address, and they come out in the reverse of arrival order: the first read yields the last digest word. Error conditions raise sticky status bits, and an enable mask gates those bits onto a single interrupt line.

All register reads are registered, so read data appears on the cycle after the read strobe.

Top module: `hash_regfront`

## Requirements
- R1: After rst_ni is released, every register reads 0 except the revision register. irq_o, eng_start_o and eng_data_valid_o are 0.
- R2: Writing 1 to bit 0 of offset 0x00 holds the block in soft reset. While it is held, offset 0x00 reads 1, every other register is cleared, writes to other offsets are ignored, and data writes are dropped without raising any flag. Writing 0 to bit 0 of offset 0x00 releases the block, and it must then be configured again.
- R3: Offset 0x04 holds the upper 32 bits and offset 0x08 the lower 32 bits of the message length in bits. Both read back as written and drive eng_len_o.
- R4: Offset 0x0C is the control register. Bits [1:0] select the algorithm (0 MD5, 1 SHA-1, 2 SHA-224, 3 SHA-256) and bits [9:8] the byte order; the register reads back those fields. A write to it raises eng_start_o for one cycle, on the cycle after the write, with eng_algo_o and eng_byte_order_o showing the new fields.
- R5: A data write is accepted only when at least two cycles separate it from the latest control write, meaning the third cycle after that write or later. An accepted word appears on eng_data_o with eng_data_valid_o high for the one cycle after its write.
- R6: A data write that arrives before any control write, or inside the two-cycle gap, is dropped and sets status bit 3 (message write error).
- R7: The block captures exactly 4, 5, 7 or 8 returned words for algorithms 0, 1, 2 and 3 respectively. Status bit 0 (results available) is set by any captured word. Status bit 1 (new results set) is set when the last expected word is captured.
- R8: Reads of offset 0x1C pop the captured words so that the first read returns the last word captured and the final read returns the first word captured.
- R9: A read of offset 0x1C while no word is held returns 0 and sets status bit 2 (result read error).
- R10: Offset 0x10 reads status bits [3:0], and bit 8 equals the OR of status[3:0] AND enable[3:0]. Offset 0x14 holds the enable mask. Writing 1s to offset 0x18 clears the matching status bits. irq_o equals status bit 8.
- R11: Offset 0x50 returns the REVISION parameter.
- R12: Reads of any other offset return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid the cycle after reg_re_i |
| data_we_i | input | 1 | Message data write strobe |
| data_i | input | 32 | Message data word |
| eng_start_o | output | 1 | One-cycle start command to the engine |
| eng_algo_o | output | 2 | Selected algorithm |
| eng_byte_order_o | output | 2 | Selected byte order |
| eng_len_o | output | 64 | Message length in bits |
| eng_data_valid_o | output | 1 | Accepted data word valid |
| eng_data_o | output | 32 | Accepted data word |
| eng_res_valid_i | input | 1 | Engine digest word valid |
| eng_res_i | input | 32 | Engine digest word |
| irq_o | output | 1 | Interrupt request |

## Verification
Several properties are checked on every cycle. The result store never holds more than its depth. A forwarded data word is never within two cycles of a control write. An empty queue read always leaves the read-error bit set. Soft reset always leaves status and irq_o at zero. A clear write always removes the bits it names unless those bits are being set in the same cycle. Other behaviour can only be shown by the bench scenarios: the reverse pop order of real digest sequences, the exact word count for each algorithm, the register readback, the masking of the interrupt, and the ignoring of undefined offsets.

// File: rtl/hrf_pkg.sv
package hrf_pkg;
  localparam logic [7:0] OFF_SRST  = 8'h00;
  localparam logic [7:0] OFF_LENHI = 8'h04;
  localparam logic [7:0] OFF_LENLO = 8'h08;
  localparam logic [7:0] OFF_CTRL  = 8'h0C;
  localparam logic [7:0] OFF_STAT  = 8'h10;
  localparam logic [7:0] OFF_EN    = 8'h14;
  localparam logic [7:0] OFF_CLR   = 8'h18;
  localparam logic [7:0] OFF_QUEUE = 8'h1C;
  localparam logic [7:0] OFF_REV   = 8'h50;

  typedef enum logic [1:0] {
    ALG_MD5    = 2'd0,
    ALG_SHA1   = 2'd1,
    ALG_SHA224 = 2'd2,
    ALG_SHA256 = 2'd3
  } algo_e;

  // status bit positions
  localparam int ST_AVAIL  = 0;
  localparam int ST_DONE   = 1;
  localparam int ST_RD_ERR = 2;
  localparam int ST_WR_ERR = 3;

  function automatic int digest_words(algo_e a);
    case (a)
      ALG_MD5:    return 4;
      ALG_SHA1:   return 5;
      ALG_SHA224: return 7;
      default:    return 8;
    endcase
  endfunction
endpackage

// File: rtl/hrf_result_stack.sv
module hrf_result_stack #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] top_o,
  output logic          empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] cnt;
  logic [PW-1:0] top_idx;
  logic          pop_ok, push_ok;

  assign top_idx = PW'(cnt - 1'b1);
  assign empty_o = (cnt == '0);
  assign top_o   = empty_o ? '0 : mem[top_idx];
  assign pop_ok  = pop_i && !empty_o;
  assign push_ok = push_i && ((cnt < CW'(DEPTH)) || pop_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt <= '0;
    end else if (flush_i) begin
      cnt <= '0;
    end else begin
      case ({push_ok, pop_ok})
        2'b10: begin
          mem[PW'(cnt)] <= din_i;
          cnt <= cnt + 1'b1;
        end
        2'b01: cnt <= cnt - 1'b1;
        2'b11: mem[top_idx] <= din_i;
        default: ;
      endcase
    end
  end

  p_depth_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(DEPTH));
  p_pop_shrinks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_ok && !push_i && !flush_i) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/hrf_data_gate.sv
module hrf_data_gate #(
  parameter int DW  = 32,
  parameter int GAP = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          ctl_wr_i,
  input  logic          data_we_i,
  input  logic [DW-1:0] data_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic          wr_err_o
);
  localparam int GW = $clog2(GAP + 1);

  logic          cfg_ok;
  logic [GW-1:0] gap_cnt;
  logic          accept;

  assign accept   = data_we_i && cfg_ok && (gap_cnt == '0) && !ctl_wr_i && !flush_i;
  assign wr_err_o = data_we_i && !flush_i && !accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_ok  <= 1'b0;
      gap_cnt <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (flush_i) begin
      cfg_ok  <= 1'b0;
      gap_cnt <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= accept;
      if (accept) data_o <= data_i;
      if (ctl_wr_i) begin
        cfg_ok  <= 1'b1;
        gap_cnt <= GW'(GAP);
      end else if (gap_cnt != '0) begin
        gap_cnt <= gap_cnt - 1'b1;
      end
    end
  end

  // two idle cycles between control write and first accepted word
  p_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (!$past(ctl_wr_i) && !$past(ctl_wr_i, 2) && !$past(ctl_wr_i, 3)));
endmodule

// File: rtl/hrf_irq_ctrl.sv
module hrf_irq_ctrl #(
  parameter int NB = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic [NB-1:0] set_i,
  input  logic          clr_we_i,
  input  logic          en_we_i,
  input  logic [NB-1:0] wdata_i,
  output logic [NB-1:0] status_o,
  output logic [NB-1:0] en_o,
  output logic          irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= '0;
      en_o     <= '0;
    end else if (flush_i) begin
      status_o <= '0;
      en_o     <= '0;
    end else begin
      // a set in the same cycle wins over a clear
      status_o <= (status_o & ~(clr_we_i ? wdata_i : '0)) | set_i;
      if (en_we_i) en_o <= wdata_i;
    end
  end

  assign irq_o = |(status_o & en_o);

  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && !flush_i) |=> ((status_o & $past(wdata_i & ~set_i)) == '0));
endmodule

// File: rtl/hash_regfront.sv
module hash_regfront
  import hrf_pkg::*;
#(
  parameter int          DW       = 32,
  parameter int          AW       = 8,
  parameter int          QDEPTH   = 8,
  parameter int          GAP      = 2,
  parameter logic [31:0] REVISION = 32'h0001_0203
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          data_we_i,
  input  logic [DW-1:0] data_i,
  output logic          eng_start_o,
  output logic [1:0]    eng_algo_o,
  output logic [1:0]    eng_byte_order_o,
  output logic [2*DW-1:0] eng_len_o,
  output logic          eng_data_valid_o,
  output logic [DW-1:0] eng_data_o,
  input  logic          eng_res_valid_i,
  input  logic [DW-1:0] eng_res_i,
  output logic          irq_o
);
  localparam int CW = $clog2(QDEPTH + 1);
  localparam int NB = 4;

  logic          srst_q;
  logic          live_wr, live_rd, ctl_wr, pop, push, done, rd_err, wr_err;
  logic [DW-1:0] len_hi, len_lo, q_top, rd_mux;
  logic [1:0]    algo_q, bo_q;
  logic [CW-1:0] rx_cnt, exp_words;
  logic          q_empty;
  logic [NB-1:0] status, en, set_vec;

  assign live_wr = reg_we_i && !srst_q;
  assign live_rd = reg_re_i && !srst_q;
  assign ctl_wr  = live_wr && (reg_addr_i == AW'(OFF_CTRL));
  assign pop     = live_rd && (reg_addr_i == AW'(OFF_QUEUE));
  assign rd_err  = pop && q_empty;

  assign exp_words = CW'(digest_words(algo_e'(algo_q)));
  assign push      = eng_res_valid_i && !srst_q && !ctl_wr && (rx_cnt < exp_words);
  assign done      = push && ((rx_cnt + 1'b1) == exp_words);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srst_q      <= 1'b0;
      len_hi      <= '0;
      len_lo      <= '0;
      algo_q      <= '0;
      bo_q        <= '0;
      eng_start_o <= 1'b0;
      rx_cnt      <= '0;
    end else begin
      if (reg_we_i && reg_addr_i == AW'(OFF_SRST)) srst_q <= reg_wdata_i[0];
      if (srst_q) begin
        len_hi      <= '0;
        len_lo      <= '0;
        algo_q      <= '0;
        bo_q        <= '0;
        eng_start_o <= 1'b0;
        rx_cnt      <= '0;
      end else begin
        eng_start_o <= ctl_wr;
        if (live_wr && reg_addr_i == AW'(OFF_LENHI)) len_hi <= reg_wdata_i;
        if (live_wr && reg_addr_i == AW'(OFF_LENLO)) len_lo <= reg_wdata_i;
        if (ctl_wr) begin
          algo_q <= reg_wdata_i[1:0];
          bo_q   <= reg_wdata_i[9:8];
          rx_cnt <= '0;
        end else if (push) begin
          rx_cnt <= rx_cnt + 1'b1;
        end
      end
    end
  end

  assign eng_algo_o       = algo_q;
  assign eng_byte_order_o = bo_q;
  assign eng_len_o        = {len_hi, len_lo};

  hrf_result_stack #(.DW(DW), .DEPTH(QDEPTH)) u_stack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (srst_q || ctl_wr),
    .push_i  (push),
    .din_i   (eng_res_i),
    .pop_i   (pop),
    .top_o   (q_top),
    .empty_o (q_empty)
  );

  hrf_data_gate #(.DW(DW), .GAP(GAP)) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (srst_q),
    .ctl_wr_i  (ctl_wr),
    .data_we_i (data_we_i),
    .data_i    (data_i),
    .valid_o   (eng_data_valid_o),
    .data_o    (eng_data_o),
    .wr_err_o  (wr_err)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[ST_AVAIL]  = push;
    set_vec[ST_DONE]   = done;
    set_vec[ST_RD_ERR] = rd_err;
    set_vec[ST_WR_ERR] = wr_err;
  end

  hrf_irq_ctrl #(.NB(NB)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (srst_q),
    .set_i    (set_vec),
    .clr_we_i (live_wr && reg_addr_i == AW'(OFF_CLR)),
    .en_we_i  (live_wr && reg_addr_i == AW'(OFF_EN)),
    .wdata_i  (reg_wdata_i[NB-1:0]),
    .status_o (status),
    .en_o     (en),
    .irq_o    (irq_o)
  );

  always_comb begin
    case (reg_addr_i)
      AW'(OFF_SRST):  rd_mux = {{(DW-1){1'b0}}, srst_q};
      AW'(OFF_LENHI): rd_mux = len_hi;
      AW'(OFF_LENLO): rd_mux = len_lo;
      AW'(OFF_CTRL):  rd_mux = {{(DW-10){1'b0}}, bo_q, 6'b0, algo_q};
      AW'(OFF_STAT):  rd_mux = {{(DW-9){1'b0}}, irq_o, {(8-NB){1'b0}}, status};
      AW'(OFF_EN):    rd_mux = {{(DW-NB){1'b0}}, en};
      AW'(OFF_QUEUE): rd_mux = q_top;
      AW'(OFF_REV):   rd_mux = REVISION;
      default:        rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       reg_rdata_o <= '0;
    else if (reg_re_i) reg_rdata_o <= rd_mux;
    else               reg_rdata_o <= '0;
  end

  p_rd_err_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && q_empty) |=> status[ST_RD_ERR]);
  p_srst_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_q |=> (status == '0 && !irq_o && !eng_data_valid_o));
  p_start_fields_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> (eng_algo_o == $past(reg_wdata_i[1:0])));
endmodule

// File: tb/hash_regfront_bench.sv
`timescale 1ns/1ps
module hash_regfront_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        data_we = 1'b0;
  logic [31:0] data_w = '0;
  logic        eng_start, eng_dv, eng_rv = 1'b0, irq;
  logic [1:0]  eng_algo, eng_bo;
  logic [63:0] eng_len;
  logic [31:0] eng_data, eng_res = '0;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  hash_regfront u_hash_regfront (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_re_i(reg_re), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .data_we_i(data_we), .data_i(data_w),
    .eng_start_o(eng_start), .eng_algo_o(eng_algo), .eng_byte_order_o(eng_bo),
    .eng_len_o(eng_len), .eng_data_valid_o(eng_dv), .eng_data_o(eng_data),
    .eng_res_valid_i(eng_rv), .eng_res_i(eng_res), .irq_o(irq)
  );

  function automatic int nwords(logic [1:0] a);
    return (a == 2'd0) ? 4 : (a == 2'd1) ? 5 : (a == 2'd2) ? 7 : 8;
  endfunction
  function automatic logic [31:0] word_val(logic [1:0] a, int i);
    return 32'hD000_0000 + 32'(a) * 256 + 32'(i);
  endfunction

  // engine model: after start, a short delay, then the digest words one per cycle
  initial begin
    forever begin
      @(negedge clk);
      if (eng_start) begin
        logic [1:0] a;
        a = eng_algo;
        repeat (5) @(negedge clk);
        for (int i = 0; i < nwords(a); i++) begin
          eng_rv = 1'b1; eng_res = word_val(a, i);
          @(negedge clk);
        end
        eng_rv = 1'b0;
      end
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_re = 1'b1; reg_addr = a;
    @(negedge clk); d = reg_rdata; reg_re = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, 64'(d), 64'(exp));
  endtask

  // single data write; returns whether it was forwarded
  task automatic dwr(logic [31:0] d, output logic fwd);
    @(negedge clk); data_we = 1'b1; data_w = d;
    @(negedge clk); fwd = eng_dv; data_we = 1'b0;
  endtask

  initial begin
    logic f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 irq", 64'(irq), 0);
    chk("R1 start", 64'(eng_start), 0);
    chk("R1 dvalid", 64'(eng_dv), 0);
    rd_chk("R1 status", 8'h10, 0);
    rd_chk("R1 ctrl", 8'h0C, 0);
    rd_chk("R1 srst", 8'h00, 0);
    rd_chk("R11 revision", 8'h50, 32'h0001_0203);

    // R6 data before any configuration
    dwr(32'h1111_1111, f);
    chk("R6 unconfigured not forwarded", 64'(f), 0);
    rd_chk("R6 write error bit", 8'h10, 32'h8);
    wr(8'h18, 32'hF);
    rd_chk("R10 clear", 8'h10, 0);

    // R3 length registers
    wr(8'h04, 32'h0000_0001);
    wr(8'h08, 32'h8000_0040);
    rd_chk("R3 len hi", 8'h04, 32'h0000_0001);
    rd_chk("R3 len lo", 8'h08, 32'h8000_0040);
    chk("R3 len port", eng_len, 64'h0000_0001_8000_0040);

    // R5 / R6 two-cycle gap after control write
    wr(8'h0C, 32'h0000_0001);
    data_we = 1'b1; data_w = 32'hA1;
    @(negedge clk); chk("R5 gap cycle 1 blocked", 64'(eng_dv), 0); data_w = 32'hA2;
    @(negedge clk); chk("R5 gap cycle 2 blocked", 64'(eng_dv), 0); data_w = 32'hA3;
    @(negedge clk); chk("R5 third cycle accepted", 64'(eng_dv), 1);
    chk("R5 forwarded word", 64'(eng_data), 64'h0A3); data_we = 1'b0;
    @(negedge clk); chk("R5 single-cycle valid", 64'(eng_dv), 0);
    repeat (20) @(negedge clk);
    rd_chk("R6 gap write error", 8'h10, 32'hB);
    wr(8'h18, 32'hF);

    // R4 R7 R8 R9 R10 every algorithm
    wr(8'h14, 32'h2);
    for (int a = 0; a < 4; a++) begin
      logic [1:0] bo;
      logic [31:0] d;
      bo = 2'(a) ^ 2'b01;
      wr(8'h0C, {22'b0, bo, 6'b0, 2'(a)});
      chk("R4 start pulse", 64'(eng_start), 1);
      chk("R4 algo port", 64'(eng_algo), 64'(a));
      chk("R4 byte order port", 64'(eng_bo), 64'(bo));
      @(negedge clk);
      chk("R4 start one cycle", 64'(eng_start), 0);
      repeat (20) @(negedge clk);
      rd_chk("R4 ctrl readback", 8'h0C, {22'b0, bo, 6'b0, 2'(a)});
      rd_chk("R7 avail+done with summary", 8'h10, 32'h103);
      chk("R10 irq on enabled done", 64'(irq), 1);
      for (int i = nwords(2'(a)) - 1; i >= 0; i--) begin
        rd(8'h1C, d);
        chk("R8 reverse pop order", 64'(d), 64'(word_val(2'(a), i)));
      end
      rd_chk("R9 empty read zero", 8'h1C, 0);
      rd_chk("R9 read error bit", 8'h10, 32'h107);
      wr(8'h18, 32'hF);
      rd_chk("R10 cleared", 8'h10, 0);
      chk("R10 irq low after clear", 64'(irq), 0);
    end

    // R10 masking
    wr(8'h14, 32'h0);
    rd_chk("R9 empty read", 8'h1C, 0);
    rd_chk("R10 masked summary", 8'h10, 32'h4);
    chk("R10 masked irq", 64'(irq), 0);
    wr(8'h14, 32'h4);
    rd_chk("R10 enable readback", 8'h14, 32'h4);
    rd_chk("R10 unmasked summary", 8'h10, 32'h104);
    chk("R10 unmasked irq", 64'(irq), 1);
    wr(8'h18, 32'h4);
    rd_chk("R10 selective clear", 8'h10, 0);

    // R12 undefined offsets
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    rd_chk("R12 read 0x24", 8'h24, 0);
    rd_chk("R12 read 0x40", 8'h40, 0);
    rd_chk("R12 status untouched", 8'h10, 0);
    rd_chk("R12 ctrl untouched", 8'h0C, 32'h0000_0203);
    rd_chk("R12 len untouched", 8'h08, 32'h8000_0040);

    // R2 soft reset
    wr(8'h00, 32'h1);
    rd_chk("R2 held reads 1", 8'h00, 1);
    rd_chk("R2 len cleared", 8'h08, 0);
    rd_chk("R2 ctrl cleared", 8'h0C, 0);
    wr(8'h08, 32'h1234_5678);
    rd_chk("R2 write ignored", 8'h08, 0);
    dwr(32'h55, f);
    chk("R2 data dropped", 64'(f), 0);
    wr(8'h00, 32'h0);
    rd_chk("R2 released", 8'h00, 0);
    rd_chk("R2 no flag while held", 8'h10, 0);
    rd_chk("R2 enable cleared", 8'h14, 0);
    dwr(32'h66, f);
    chk("R2 needs reconfigure", 64'(f), 0);
    rd_chk("R2 R6 error after release", 8'h10, 32'h8);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule